// File: doc/BRIEF.md
# Four-Beat Burst Dual-Port SRAM Core

This block is a small on-chip memory with one shared address bus, a write-data port and a separate read-data port. Both ports run at the same time. Each command moves four words. The block is clocked by a beat clock that runs at twice the command rate. A phase flop inside the block marks every other beat edge as a main edge, and that mark is exported as `main_edge`. Commands are sampled only on main edges. A write takes its address one beat after its command, so a read address and a write address can share the bus within one command cycle.

Two copies of one burst state machine control the block, one for reads and one for writes. Each has four states: `ST_IDLE`, `ST_LOAD`, `ST_FIRST` and `ST_SECOND`. State changes happen only on main edges:
- `ST_IDLE` moves to `ST_LOAD` on a command.
- `ST_LOAD` always moves to `ST_FIRST`. On that edge the first beat moves.
- `ST_FIRST` moves to `ST_LOAD` on a command, otherwise to `ST_SECOND`.
- `ST_SECOND` moves to `ST_LOAD` on a command, otherwise to `ST_IDLE`.

A four-beat sequencer keeps counting the burst address on its own. This lets a new command's load cycle overlap the last beat pair of the previous burst. Writes are masked per 9-bit lane. When a read beat and a write beat hit the same word on the same edge, the read data is taken from the incoming write data, lane by lane.

Top module: `qb_sram_core`

## Requirements
- R1: After reset, `rd_valid` is low, `rd_data` is zero and `main_edge` is high, so the first beat edge after reset is a main edge.
- R2: `rd_n` low at a main edge `c` starts a read burst at `addr`. The four words appear on `rd_data`, with `rd_valid` high, after edges c+2, c+3, c+4 and c+5.
- R3: `wr_n` low at a main edge `c` starts a write burst. Its base address is taken from `addr` at edge c+1. Its four data beats and lane enables are taken at edges c+2 to c+5.
- R4: Beat k of a burst (k = 0..3) uses address (base + k) modulo the memory depth, so a burst based at depth-2 wraps around to address 0.
- R5: A second command of the same kind at main edge c+2 is ignored. At c+4 it is accepted, and its data follows the earlier burst with no gap.
- R6: Strobes that are low only at edges where `main_edge` is low start nothing.
- R7: A read burst and a write burst can be started on the same main edge. They run independently.
- R8: `lane_we_n[l]` is active low and gates bits [9l+8:9l] of a write beat. With all four bits high, the beat writes nothing.
- R9: A read beat returns the word as it stands after any write beat on the same edge. Lanes enabled in that write come from `wr_data`; the other lanes come from memory.
- R10: On every edge that carries no read beat, `rd_valid` is low and `rd_data` is zero. After a burst with no follow-on read, `rd_valid` drops at edge c+6.
- R11: `wr_data` and `lane_we_n` at edges that carry no write beat leave the memory unchanged.
- R12: `main_edge` toggles on every beat edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock, two beats per command cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_edge | output | 1 | High when the next rising edge is a main (command) edge |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | ADDR_W | Shared address bus: read address on main edges, write address on the following edge |
| lane_we_n | input | LANES | Active-low per-lane write enables |
| wr_data | input | LANES*LANE_W | Write beat data |
| rd_data | output | LANES*LANE_W | Read beat data, zero when not valid |
| rd_valid | output | 1 | High while `rd_data` carries a read beat |

## Verification
The assertions assume that `rd_n` is a known value on every edge once reset is released. They also assume that inputs settle between clock edges. Under those assumptions, any rise of `rd_valid` can be traced back exactly three edges to a low read strobe on a main edge.

The bench keeps within these assumptions. It drives every input on the falling edge of the clock. It issues commands in two-beat units that start on main edges, except in the one case that deliberately puts the strobes on odd edges. It also writes every word in full before the first read, so every expected value is defined.

// File: rtl/qb_pkg.sv
package qb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FIRST,
        ST_SECOND
    } burst_st_e;

    localparam int BEATS_PER_BURST = 4;

endpackage

// File: rtl/qb_burst_fsm.sv
module qb_burst_fsm
    import qb_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter bit ADDR_LATE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_edge,
    input  logic              cmd,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              beat_o,
    output logic [ADDR_W-1:0] beat_addr_o
);

    localparam int          CNT_W    = $clog2(BEATS_PER_BURST);
    localparam logic [CNT_W-1:0] TAIL_BEATS = CNT_W'(BEATS_PER_BURST - 1);
    localparam logic [CNT_W-1:0] LAST_LEFT  = CNT_W'(1);

    burst_st_e         st_q;
    burst_st_e         st_d;
    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] next_q;
    logic [CNT_W-1:0]  left_q;
    logic              run_q;
    logic              accept;
    logic              start;
    logic              grab;

    // A command is taken on a main edge unless the previous one of this
    // kind is still in its load cycle.
    assign accept = main_edge && cmd && (st_q != ST_LOAD);
    assign start  = main_edge && (st_q == ST_LOAD);

    generate
        if (ADDR_LATE) begin : g_late_addr
            assign grab = (st_q == ST_LOAD) && !main_edge;
        end else begin : g_early_addr
            assign grab = accept;
        end
    endgenerate

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic, evaluated on main edges only
    always_comb begin
        st_d = st_q;
        if (main_edge) begin
            unique case (st_q)
                ST_IDLE:   st_d = cmd ? ST_LOAD : ST_IDLE;
                ST_LOAD:   st_d = ST_FIRST;
                ST_FIRST:  st_d = cmd ? ST_LOAD : ST_SECOND;
                ST_SECOND: st_d = cmd ? ST_LOAD : ST_IDLE;
                default:   st_d = ST_IDLE;
            endcase
        end
    end

    // Base address register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (grab) begin
            base_q <= addr_in;
        end
    end

    // Beat sequencer: runs the three beats after the first one, free of
    // the state register so a new load can overlap the tail.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            left_q <= '0;
            next_q <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            left_q <= TAIL_BEATS;
            next_q <= base_q + ADDR_W'(1);
        end else if (run_q) begin
            run_q  <= (left_q != LAST_LEFT);
            left_q <= left_q - LAST_LEFT;
            next_q <= next_q + ADDR_W'(1);
        end
    end

    // Beat outputs
    always_comb begin
        beat_o      = start || run_q;
        beat_addr_o = start ? base_q : next_q;
    end

endmodule

// File: rtl/qb_store.sv
module qb_store #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_bank
            logic [LANE_W-1:0] bank [DEPTH];

            always_ff @(posedge clk) begin
                if (we && !lane_we_n[l]) begin
                    bank[waddr] <= wdata[l*LANE_W +: LANE_W];
                end
            end

            assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
        end
    endgenerate

endmodule

// File: rtl/qb_fwd_merge.sv
module qb_fwd_merge #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic [LANES*LANE_W-1:0] mem_word,
    input  logic [LANES*LANE_W-1:0] wr_word,
    input  logic                    hit,
    input  logic [LANES-1:0]        lane_we_n,
    output logic [LANES*LANE_W-1:0] word_o
);

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign word_o[l*LANE_W +: LANE_W] = (hit && !lane_we_n[l])
                                              ? wr_word[l*LANE_W +: LANE_W]
                                              : mem_word[l*LANE_W +: LANE_W];
        end
    endgenerate

endmodule

// File: rtl/qb_sram_core.sv
module qb_sram_core #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic                    main_edge,
    input  logic                    rd_n,
    input  logic                    wr_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);

    localparam int WORD_W = LANES * LANE_W;

    logic              odd_q;
    logic              rd_beat;
    logic              wr_beat;
    logic [ADDR_W-1:0] rd_baddr;
    logic [ADDR_W-1:0] wr_baddr;
    logic [WORD_W-1:0] mem_word;
    logic [WORD_W-1:0] rd_word;
    logic              fwd_hit;

    // Beat phase: low phase precedes a main edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            odd_q <= 1'b0;
        end else begin
            odd_q <= ~odd_q;
        end
    end

    assign main_edge = ~odd_q;

    qb_burst_fsm #(
        .ADDR_W    (ADDR_W),
        .ADDR_LATE (1'b0)
    ) u_rd_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_edge   (main_edge),
        .cmd         (~rd_n),
        .addr_in     (addr),
        .beat_o      (rd_beat),
        .beat_addr_o (rd_baddr)
    );

    qb_burst_fsm #(
        .ADDR_W    (ADDR_W),
        .ADDR_LATE (1'b1)
    ) u_wr_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .main_edge   (main_edge),
        .cmd         (~wr_n),
        .addr_in     (addr),
        .beat_o      (wr_beat),
        .beat_addr_o (wr_baddr)
    );

    qb_store #(
        .ADDR_W (ADDR_W),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_store (
        .clk       (clk),
        .we        (wr_beat),
        .waddr     (wr_baddr),
        .lane_we_n (lane_we_n),
        .wdata     (wr_data),
        .raddr     (rd_baddr),
        .rdata     (mem_word)
    );

    assign fwd_hit = wr_beat && rd_beat && (wr_baddr == rd_baddr);

    qb_fwd_merge #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_fwd (
        .mem_word  (mem_word),
        .wr_word   (wr_data),
        .hit       (fwd_hit),
        .lane_we_n (lane_we_n),
        .word_o    (rd_word)
    );

    // Read output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else if (rd_beat) begin
            rd_data  <= rd_word;
            rd_valid <= 1'b1;
        end else begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/qb_sram_core_chk.sv
module qb_sram_core_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              main_edge,
    input logic              rd_n,
    input logic              rd_valid,
    input logic [WORD_W-1:0] rd_data
);

    logic [2:0] age_q;
    logic [1:0] vrun_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 3'd4) begin
            age_q <= age_q + 3'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vrun_q <= '0;
        end else begin
            vrun_q <= rd_valid ? vrun_q + 2'd1 : 2'd0;
        end
    end

    assert_phase_toggle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 3'd0) |-> (main_edge != $past(main_edge)));

    assert_quiet_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0));

    assert_start_from_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q >= 3'd3) && $rose(rd_valid)) |-> ($past(rd_n, 3) == 1'b0));

    assert_start_on_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q >= 3'd3) && $rose(rd_valid)) |-> $past(main_edge, 3));

    assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_valid) |-> (vrun_q == 2'd0));

endmodule

bind qb_sram_core qb_sram_core_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_edge (main_edge),
    .rd_n      (rd_n),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
);

// File: tb/test_qb_sram_core.sv
module test_qb_sram_core;

    localparam int AW    = 6;
    localparam int NL    = 4;
    localparam int LW    = 9;
    localparam int WW    = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          main_edge;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] lane_we_n = '1;
    logic [WW-1:0] wr_data = '0;
    logic [WW-1:0] rd_data;
    logic          rd_valid;

    always #5 clk = ~clk;

    qb_sram_core #(
        .ADDR_W (AW),
        .LANES  (NL),
        .LANE_W (LW)
    ) i_qb_sram_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_edge (main_edge),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .lane_we_n (lane_we_n),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int n       = 0;
    int rd_ok   = 0;
    int wr_ok   = 0;
    string cur_req = "R1";
    logic [NL-1:0] cur_bw = '0;
    logic [WW-1:0] mm [DEPTH];
    int rd_at [int];
    int wr_at [int];
    int wpend [int];
    logic [WW-1:0] exp_q = '0;
    logic          exp_v = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at beat %0d: actual %h expected %h", req, n, act, expv);
        end
    endtask

    function automatic logic [WW-1:0] mk(input int e);
        return {LW'(e * 37 + 5), LW'(e * 11 + 200), LW'(e * 53 + 17), LW'(e * 3 + 99)};
    endfunction

    // One beat: check the previous edge, drive, predict the coming edge.
    task automatic beat(input logic rdn, input logic wrn, input int a);
        logic [WW-1:0] dd;
        dd = mk(n);
        chk(rd_valid === exp_v, exp_v ? cur_req : "R10", 64'(rd_valid), 64'(exp_v));
        chk(rd_data === exp_q, exp_v ? cur_req : "R10", 64'(rd_data), 64'(exp_q));
        chk(main_edge === (n % 2 == 0), "R12", 64'(main_edge), 64'(n % 2 == 0));
        rd_n = rdn; wr_n = wrn; addr = AW'(a); lane_we_n = cur_bw; wr_data = dd;
        if (n % 2 == 0) begin
            if (!rdn && n >= rd_ok) begin
                rd_ok = n + 4;
                for (int k = 0; k < 4; k++) rd_at[n + 2 + k] = (a + k) % DEPTH;
            end
            if (!wrn && n >= wr_ok) begin
                wr_ok = n + 4;
                wpend[n + 1] = 1;
            end
        end else if (wpend.exists(n)) begin
            for (int k = 0; k < 4; k++) wr_at[n + 1 + k] = (a + k) % DEPTH;
            wpend.delete(n);
        end
        if (wr_at.exists(n)) begin
            for (int l = 0; l < NL; l++)
                if (!cur_bw[l]) mm[wr_at[n]][l*LW +: LW] = dd[l*LW +: LW];
            wr_at.delete(n);
        end
        if (rd_at.exists(n)) begin
            exp_q = mm[rd_at[n]];
            exp_v = 1'b1;
            rd_at.delete(n);
        end else begin
            exp_q = '0;
            exp_v = 1'b0;
        end
        @(posedge clk);
        n++;
        @(negedge clk);
    endtask

    task automatic mc(input logic rdn, input logic wrn, input int ra, input int wa);
        beat(rdn, wrn, ra);
        beat(1'b1, 1'b1, wa);
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) mc(1'b1, 1'b1, 0, 0);
    endtask

    task automatic rd_one(input int a);
        mc(1'b0, 1'b1, a, 0);
        idle(3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) mm[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk(rd_valid === 1'b0, "R1", 64'(rd_valid), 64'd0);
        chk(rd_data === '0, "R1", 64'(rd_data), 64'd0);
        chk(main_edge === 1'b1, "R1", 64'(main_edge), 64'd1);

        // R3: fill memory with gapless write bursts
        cur_req = "R3"; cur_bw = '0;
        for (int i = 0; i < DEPTH / 4; i++) begin
            mc(1'b1, 1'b0, 0, i * 4);
            idle(1);
        end
        idle(3);

        // R2: gapless reads of every burst
        cur_req = "R2";
        for (int i = 0; i < DEPTH / 4; i++) begin
            mc(1'b0, 1'b1, i * 4, 0);
            idle(1);
        end
        idle(3);

        // R5: commands one cycle after acceptance are ignored
        cur_req = "R5";
        mc(1'b0, 1'b0, 8, 20);
        mc(1'b0, 1'b0, 40, 44);
        idle(4);
        rd_one(44);
        rd_one(20);
        rd_one(40);

        // R6: strobes on non-main edges start nothing
        cur_req = "R6";
        for (int i = 0; i < 3; i++) begin
            beat(1'b1, 1'b1, 12);
            beat(1'b0, 1'b0, 12);
        end
        idle(4);
        rd_one(12);

        // R7: concurrent read and write bursts
        cur_req = "R7";
        mc(1'b0, 1'b0, 24, 48);
        idle(1);
        mc(1'b0, 1'b0, 48, 28);
        idle(4);
        rd_one(28);

        // R8: lane masks, including all-high
        cur_req = "R8";
        cur_bw = 4'b1110; mc(1'b1, 1'b0, 0, 4);  idle(3);
        cur_bw = 4'b1010; mc(1'b1, 1'b0, 0, 8);  idle(3);
        cur_bw = 4'b1111; mc(1'b1, 1'b0, 0, 12); idle(3);
        cur_bw = 4'b1111;
        rd_one(4); rd_one(8); rd_one(12);

        // R9: same-edge forwarding with partial lanes and offsets
        cur_req = "R9";
        cur_bw = 4'b0110; mc(1'b0, 1'b0, 32, 32); idle(4);
        cur_bw = 4'b1001; mc(1'b0, 1'b0, 37, 36); idle(4);
        cur_bw = 4'b0000; mc(1'b1, 1'b0, 0, 16); mc(1'b0, 1'b1, 18, 0); idle(4);
        cur_bw = 4'b1111;
        rd_one(32); rd_one(36); rd_one(16);

        // R11: data driven with lanes enabled outside any write burst
        cur_req = "R11";
        cur_bw = 4'b0000; idle(5);
        cur_bw = 4'b1111;
        rd_one(0); rd_one(52);

        // R4: wrap at the top of memory
        cur_req = "R4";
        cur_bw = 4'b0000; mc(1'b1, 1'b0, 0, DEPTH - 2); idle(3);
        cur_bw = 4'b1111;
        rd_one(DEPTH - 2);
        rd_one(DEPTH - 1);

        // R10: valid drop after last read
        cur_req = "R10";
        mc(1'b0, 1'b1, 2, 0);
        idle(4);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule